// File: doc/BRIEF.md
# Center-Aligned Timer Counter with Reload Preload

This block is a programmable timer counter that runs in one of three modes: counting up, counting down, or center-aligned, where it climbs from zero to a reload limit and then falls back to zero, over and over. A prescaler divides the input clock so the counter only moves on prescaler ticks while counting is enabled. When the counter crosses its turning points it raises update events, and software can force one with a one-cycle strobe. Each update event sets a sticky interrupt flag and commits the pending reload and divider values to their working copies.

The reload limit has an optional preload stage. With preload off, a write to the limit takes effect at once, so the next wrap already uses it. With preload on, the value waits until the next update event. The divider value always waits for an update event. An update-disable input blocks update events completely, but the counter keeps wrapping. A direction output shows whether the counter is currently moving downward.

Top module: `ca_timer`

## Requirements
- R1: After reset `count_o` is 0, `dir_o` is 0, `update_o` is 0 and `upd_flag_o` is 0. The working reload limit resets to all ones and the working divider resets to 0.
- R2: While `cnt_en_i` is 1 the counter moves one step every (divider + 1) clock cycles. While `cnt_en_i` is 0 the counter and the prescaler hold their values.
- R3: In up mode (`mode_i` = 0) the counter steps 0, 1, ... up to the limit. The tick taken at or above the limit returns it to 0 and is an overflow.
- R4: In down mode (`mode_i` = 1) the counter steps down. The tick taken at 0 loads the limit and is an underflow. `dir_o` reads 1 in this mode.
- R5: In center-aligned mode (`mode_i` = 2 or 3) the counter rises from 0 to the limit and then falls back to 0. The tick from limit-1 up to the limit is an overflow, and that tick turns the counter downward. The tick from 1 down to 0 is an underflow, and that tick turns it upward. `dir_o` is 1 exactly while the counter is moving down.
- R6: A one-cycle pulse on `ug_i` clears the counter and the prescaler to 0 and sets the direction to upward. It takes priority over a tick in the same cycle and produces an update event.
- R7: While `upd_dis_i` is 1, overflows, underflows and `ug_i` produce no update event. `update_o` stays 0, the flag is not set, and no working value is loaded. The counter still wraps.
- R8: `update_o` is high for one cycle, in the same cycle the counter shows the value produced by the event tick. The same event sets `upd_flag_o`. The flag then stays 1 until a `flag_clr_i` pulse, and a set in the same cycle wins over the clear.
- R9: With `preload_en_i` = 0, a write on `arl_we_i` replaces the working limit at the next clock edge.
- R10: With `preload_en_i` = 1, a written limit is held back until an update event. The divider written through `psc_we_i` is always held back until an update event.
- R11: A working limit of 0 forces the counter to 0 and produces no overflow or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counting enable |
| mode_i | input | 2 | 0 up, 1 down, 2 or 3 center-aligned |
| preload_en_i | input | 1 | Hold back limit writes until an update event |
| upd_dis_i | input | 1 | Suppress update events |
| ug_i | input | 1 | Software update strobe |
| flag_clr_i | input | 1 | Clear the update flag |
| arl_wdata_i | input | CNT_W | Reload limit write data |
| arl_we_i | input | 1 | Reload limit write strobe |
| psc_wdata_i | input | PSC_W | Divider write data |
| psc_we_i | input | 1 | Divider write strobe |
| count_o | output | CNT_W | Counter value |
| dir_o | output | 1 | 1 while counting down |
| update_o | output | 1 | Update event pulse |
| upd_flag_o | output | 1 | Sticky update flag |

## Verification
The bench builds the block with an 8-bit counter and a 4-bit divider. With these widths, limits of 0, 1 and a few units reach every wrap and turnaround many times within a short run, and the all-ones reset limit stays inside the counter's range. Divider values up to 15 make the spacing of the tick pulses easy to see against the clock.

// File: rtl/ca_timer_pkg.sv
package ca_timer_pkg;
  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTER = 2'd2,
    MODE_CENTB  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/ca_tmr_shadow.sv
module ca_tmr_shadow #(
  parameter int         W              = 16,
  parameter bit         ALWAYS_PRELOAD = 1'b0,
  parameter logic [W-1:0] RST_VAL      = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         preload_en_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] pre_q;
  logic [W-1:0] act_q;
  logic         held;

  assign held = ALWAYS_PRELOAD | preload_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= RST_VAL;
      act_q <= RST_VAL;
    end else begin
      if (load_i) act_q <= pre_q;
      if (we_i) begin
        pre_q <= wdata_i;
        if (!held) act_q <= wdata_i;
      end
    end
  end

  assign act_o = act_q;

  // held value only moves on a load
  assert_preload_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !load_i) |=> $stable(act_q));
endmodule

// File: rtl/ca_tmr_prescaler.sv
module ca_tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clear_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] pc_q;

  function automatic logic at_end(input logic [W-1:0] pc, input logic [W-1:0] div);
    return pc >= div;
  endfunction

  assign tick_o = en_i && at_end(pc_q, div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= '0;
    else if (clear_i)   pc_q <= '0;
    else if (en_i)      pc_q <= tick_o ? '0 : pc_q + 1'b1;
  end

  assert_hold_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clear_i) |=> $stable(pc_q));
  assert_restart_after_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (pc_q == '0));
endmodule

// File: rtl/ca_tmr_core.sv
module ca_tmr_core
  import ca_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ug_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] arl_i,
  output logic [W-1:0] count_o,
  output logic         dir_o,
  output logic         ovf_o,
  output logic         unf_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;
  logic         is_up, is_down, is_center;

  assign is_up     = (mode_i == MODE_UP);
  assign is_down   = (mode_i == MODE_DOWN);
  assign is_center = !is_up && !is_down;

  // step helpers
  function automatic logic up_wrap(input logic [W-1:0] c, input logic [W-1:0] lim);
    return c >= lim;
  endfunction

  function automatic logic center_top(input logic [W-1:0] c, input logic [W-1:0] lim);
    return c >= (lim - 1'b1);
  endfunction

  function automatic logic center_bottom(input logic [W-1:0] c);
    return c <= {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    ovf_o  = 1'b0;
    unf_o  = 1'b0;
    if (ug_i) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (arl_i == '0) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (tick_i) begin
      if (is_up) begin
        if (up_wrap(cnt_q, arl_i)) begin
          cnt_d = '0;
          ovf_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (is_down) begin
        if (cnt_q == '0) begin
          cnt_d = arl_i;
          unf_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else if (!down_q) begin
        if (center_top(cnt_q, arl_i)) begin
          cnt_d  = arl_i;
          down_d = 1'b1;
          ovf_o  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (center_bottom(cnt_q)) begin
          cnt_d  = '0;
          down_d = 1'b0;
          unf_o  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign count_o = cnt_q;
  assign dir_o   = is_down | (is_center & down_q);

  assert_ug_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (cnt_q == '0 && !down_q));
  assert_zero_limit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arl_i == '0) |-> (!ovf_o && !unf_o));
  assert_zero_limit_cnt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arl_i == '0) |=> (cnt_q == '0));
  assert_up_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_up && ovf_o) |=> (cnt_q == '0));
  assert_center_turn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_center && ovf_o) |=> down_q);
  assert_center_bottom_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_center && unf_o) |=> (!down_q && cnt_q == '0));
endmodule

// File: rtl/ca_timer.sv
module ca_timer
  import ca_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic [1:0]       mode_i,
  input  logic             preload_en_i,
  input  logic             upd_dis_i,
  input  logic             ug_i,
  input  logic             flag_clr_i,
  input  logic [CNT_W-1:0] arl_wdata_i,
  input  logic             arl_we_i,
  input  logic [PSC_W-1:0] psc_wdata_i,
  input  logic             psc_we_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             update_o,
  output logic             upd_flag_o
);
  localparam logic [CNT_W-1:0] ARL_RST = '1;
  localparam logic [PSC_W-1:0] PSC_RST = '0;

  logic [CNT_W-1:0] arl_act;
  logic [PSC_W-1:0] psc_act;
  logic             tick;
  logic             ovf_evt, unf_evt;
  logic             upd_evt;
  logic             update_q, flag_q;

  assign upd_evt = (ovf_evt | unf_evt | ug_i) & ~upd_dis_i;

  ca_tmr_shadow #(.W(CNT_W), .ALWAYS_PRELOAD(1'b0), .RST_VAL(ARL_RST)) u_arl (
    .clk_i(clk_i), .rst_ni(rst_ni), .preload_en_i(preload_en_i),
    .we_i(arl_we_i), .wdata_i(arl_wdata_i), .load_i(upd_evt), .act_o(arl_act));

  ca_tmr_shadow #(.W(PSC_W), .ALWAYS_PRELOAD(1'b1), .RST_VAL(PSC_RST)) u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni), .preload_en_i(1'b1),
    .we_i(psc_we_i), .wdata_i(psc_wdata_i), .load_i(upd_evt), .act_o(psc_act));

  ca_tmr_prescaler #(.W(PSC_W)) u_psc_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cnt_en_i), .clear_i(ug_i),
    .div_i(psc_act), .tick_o(tick));

  ca_tmr_core #(.W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .ug_i(ug_i),
    .mode_i(mode_i), .arl_i(arl_act), .count_o(count_o), .dir_o(dir_o),
    .ovf_o(ovf_evt), .unf_o(unf_evt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      update_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      update_q <= upd_evt;
      if (upd_evt)         flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign update_o   = update_q;
  assign upd_flag_o = flag_q;

  assert_dis_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_dis_i |=> !update_o);
  assert_flag_with_update_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> upd_flag_o);
  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_flag_o && !flag_clr_i) |=> upd_flag_o);
  assert_ug_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ug_i && !upd_dis_i) |=> update_o);
endmodule

// File: tb/ca_timer_tb_top.sv
`timescale 1ns/1ps
module ca_timer_tb_top;
  localparam int CW = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          pre_en = 1'b0;
  logic          dis = 1'b0;
  logic          ug = 1'b0;
  logic          clr = 1'b0;
  logic [CW-1:0] arl_wd = '0;
  logic          arl_we = 1'b0;
  logic [PW-1:0] psc_wd = '0;
  logic          psc_we = 1'b0;
  logic [CW-1:0] count;
  logic          dir, upd, flag;

  always #2.5 clk = ~clk;

  ca_timer #(.CNT_W(CW), .PSC_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .mode_i(mode),
    .preload_en_i(pre_en), .upd_dis_i(dis), .ug_i(ug), .flag_clr_i(clr),
    .arl_wdata_i(arl_wd), .arl_we_i(arl_we), .psc_wdata_i(psc_wd),
    .psc_we_i(psc_we), .count_o(count), .dir_o(dir), .update_o(upd),
    .upd_flag_o(flag));

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  logic [CW+2:0] exp_q[$];
  string         tag_q[$];

  // reference model state
  int m_cnt, m_down, m_pc, m_psc_act, m_psc_pre, m_arl_act, m_arl_pre, m_flag;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver-side reference: predicts outputs after every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_pc = 0; m_psc_act = 0; m_psc_pre = 0;
      m_arl_act = (1 << CW) - 1; m_arl_pre = (1 << CW) - 1; m_flag = 0;
    end else begin
      int  nc, nd, npc;
      bit  tk, edge_evt, evt;
      int  dout;
      nc = m_cnt; nd = m_down; edge_evt = 0;
      tk = en && (m_pc >= m_psc_act);
      if (ug) npc = 0; else if (en) npc = tk ? 0 : m_pc + 1; else npc = m_pc;
      if (ug) begin nc = 0; nd = 0; end
      else if (m_arl_act == 0) begin nc = 0; nd = 0; end
      else if (tk) begin
        case (mode)
          2'd0: begin
            if (m_cnt < m_arl_act) nc = m_cnt + 1;
            else begin nc = 0; edge_evt = 1; end
          end
          2'd1: begin
            if (m_cnt > 0) nc = m_cnt - 1;
            else begin nc = m_arl_act; edge_evt = 1; end
          end
          default: begin
            if (m_down == 0) begin
              if (m_cnt + 1 < m_arl_act) nc = m_cnt + 1;
              else begin nc = m_arl_act; nd = 1; edge_evt = 1; end
            end else begin
              if (m_cnt > 1) nc = m_cnt - 1;
              else begin nc = 0; nd = 0; edge_evt = 1; end
            end
          end
        endcase
      end
      evt = (edge_evt || ug) && !dis;
      if (evt) begin m_arl_act = m_arl_pre; m_psc_act = m_psc_pre; end
      if (arl_we) begin m_arl_pre = arl_wd; if (!pre_en) m_arl_act = arl_wd; end
      if (psc_we) m_psc_pre = psc_wd;
      if (evt) m_flag = 1; else if (clr) m_flag = 0;
      m_cnt = nc; m_down = nd; m_pc = npc;
      dout = (mode == 2'd1) ? 1 : ((mode == 2'd0) ? 0 : m_down);
      exp_q.push_back({CW'(m_cnt), dout[0], evt, m_flag[0]});
      tag_q.push_back(cur_tag);
    end
  end

  // monitor: compares after the edge has settled
  always @(posedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      logic [CW+2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, "count", count, e[CW+2:3]);
      check(t, "dir", dir, e[2]);
      check(t, "update", upd, e[1]);
      check(t, "flag", flag, e[0]);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ug();
    @(negedge clk) ug = 1'b1;
    @(negedge clk) ug = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic wr_arl(int v);
    @(negedge clk) begin arl_wd = CW'(v); arl_we = 1'b1; end
    @(negedge clk) arl_we = 1'b0;
  endtask

  task automatic wr_psc(int v);
    @(negedge clk) begin psc_wd = PW'(v); psc_we = 1'b1; end
    @(negedge clk) psc_we = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values seen at the ports
    check("R1", "count", count, 0);
    check("R1", "dir", dir, 0);
    check("R1", "update", upd, 0);
    check("R1", "flag", flag, 0);

    cur_tag = "R3";
    mode = 2'd0;
    wr_arl(5);
    en = 1'b1;
    run(20);

    cur_tag = "R6";
    wr_psc(2);
    pulse_ug();
    cur_tag = "R2";
    run(30);
    en = 1'b0;
    run(6);
    en = 1'b1;
    run(10);

    cur_tag = "R4";
    mode = 2'd1;
    pulse_ug();
    wr_psc(0);
    pulse_ug();
    run(25);

    cur_tag = "R5";
    mode = 2'd2;
    wr_arl(4);
    pulse_ug();
    run(30);
    wr_arl(1);
    run(10);
    mode = 2'd3;
    wr_arl(3);
    run(15);

    cur_tag = "R6";
    run(2);
    pulse_ug();
    run(4);

    cur_tag = "R8";
    pulse_clr();
    run(3);
    pulse_clr();
    run(8);

    cur_tag = "R7";
    dis = 1'b1;
    pulse_clr();
    wr_psc(3);
    pulse_ug();
    run(25);
    dis = 1'b0;
    run(10);

    cur_tag = "R9";
    mode = 2'd0;
    pre_en = 1'b0;
    wr_psc(0);
    pulse_ug();
    wr_arl(6);
    run(4);
    wr_arl(2);
    run(12);

    cur_tag = "R10";
    pre_en = 1'b1;
    wr_arl(7);
    run(20);
    mode = 2'd2;
    wr_arl(2);
    run(20);
    pre_en = 1'b0;

    cur_tag = "R11";
    wr_arl(0);
    run(12);
    mode = 2'd1;
    run(6);
    wr_arl(3);
    run(10);

    run(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule